// File: doc/BRIEF.md
# Torus Tag-Passing Instruction Steering

This block decides, for a line of instruction bytes held in sixteen byte columns, which columns begin an instruction and which of four output rows carries each one. The tag units form a grid of columns and rows whose edges wrap around, so the grid is a torus. A single token, the tag, marks the unit allowed to steer next. When that unit fires, it hands its instruction to its row's output and moves the tag straight to the column that starts the next instruction, always one row further down. Rows therefore take instructions in strict rotation. Each column reports its own state: whether its instruction is ready, the length decoded on the assumption that the column starts an instruction, and flags for a predicted-taken branch and for a branch target. Each row reports whether its crossbar can take an instruction.

The row outputs follow valid/ready rules. A row's valid rises when the tag sits in that row and the tagged column's instruction is ready, and this does not depend on the row's ready. A transfer happens in any cycle where valid and ready are both high. While valid is high and ready is low, valid, start column and length hold still, and the tag does not move. In the transfer cycle the block pulses a release line for every column the instruction covers, so those byte latches can take new bytes.

A taken branch does not forward the tag. It leaves a pending token on the next row instead, and that token turns into a tag at the target column. An instruction longer than seven bytes is split in two. The head goes out as four bytes, and the tail is steered from the fifth-byte column in the next row.

Top module: `torus_steer`

## Requirements
- R1: After reset the tag is at column 0, row 0. No row is valid until column 0 reports ready, and the first transfer then appears on row 0 with start column 0.
- R2: `row_valid[r]` is high exactly when the tag is at some column c in row r and `col_ready[c]` is high, whatever the value of `row_ready[r]`. A transfer is a cycle with both `row_valid[r]` and `row_ready[r]` high. At most one row is valid in any cycle.
- R3: While the tagged row's ready is low, no release line pulses, the valid row and its start column stay unchanged, and the tag stays where it is.
- R4: After a transfer of length L (1 to 7) at column c in row r, the tag is at column (c+L) mod 16 in row (r+1) mod 4 in the next cycle. For example, a stream of 3-byte instructions transfers at (0,0), (3,1), (6,2), (9,3), (12,0), (15,1), (2,2) on consecutive cycles.
- R5: During a transfer, `row_col` gives the start column and `row_len` gives the length steered, always between 1 and 7. `col_release` is high for columns c to c+L-1 (mod 16) in that cycle only and is zero in every cycle with no transfer.
- R6: A transfer whose start column has `col_branch` high forwards no tag and makes a pending inject token on row (r+1) mod 4. No row is valid while the token waits.
- R7: When a row holds the inject token and at least one `col_target` bit is high, the token becomes a tag, at the next edge, at the lowest-numbered column with the target bit set, in that row. When no token is pending, target bits have no effect on where the tag goes.
- R8: A decoded length of 8 to 11 (encoded as that binary value) is sent as a head. The head has `row_len`=4 and `row_head`=1, and it releases 4 columns and moves the tag to column c+4 in the next row. The transfer from that column is a tail with `row_tail`=1 and `row_len`=L-4. The tail ignores its own column's decoded length and branch flag, and a branch flag on the head column takes effect when the tail transfers.
- R9: Exactly one token, either a tag or an inject token, exists in the whole grid at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_ready | input | 16 | Per column: the instruction starting here has all its bytes ready |
| col_len | input | 16×4 | Per column: decoded length, 1 to 11 |
| col_branch | input | 16 | Per column: the first byte of a predicted-taken branch |
| col_target | input | 16 | Per column: the first byte of a branch target |
| row_ready | input | 4 | Per row: the crossbar can take an instruction |
| row_valid | output | 4 | Per row: an instruction is offered |
| row_col | output | 4×4 | Per row: start column of the offered instruction |
| row_len | output | 4×4 | Per row: number of bytes steered, 1 to 7 |
| row_head | output | 1×4 | Per row: the offer is the head of a long instruction |
| row_tail | output | 1×4 | Per row: the offer is the tail of a long instruction |
| col_release | output | 16 | Per column: bytes taken this cycle |

## Verification
The row valid, start column, length, head/tail kind and release mask are combinational functions of the token state and the current inputs. They are due in the same cycle the inputs are applied. The tag moves at the next rising edge, so an ordinary successor transfer can come one cycle after its predecessor at the earliest. A branch needs one edge to create the inject token and another edge to turn it into a tag once a target bit is seen. The earliest target transfer is therefore two cycles after the branch transfer. The bench changes inputs on the falling edge and compares every output against its behavioural model a moment later. It advances the model only at the rising edge, using the inputs held across that edge.

// File: rtl/tsteer_pkg.sv
package tsteer_pkg;

  // Kind of piece a row is offering to its crossbar
  typedef enum logic [1:0] {
    XF_SHORT = 2'd0,
    XF_HEAD  = 2'd1,
    XF_TAIL  = 2'd2
  } xfer_kind_e;

  // Column arithmetic around the ring
  function automatic int ts_wrap(int a, int b, int n);
    return (a + b) % n;
  endfunction

endpackage

// File: rtl/tsteer_tail.sv
// Holds the remainder of a long instruction between its head and tail transfers
module tsteer_tail #(
  parameter int LENW    = 4,
  parameter int HEADLEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_fire,
  input  logic            head_fire,
  input  logic [LENW-1:0] head_len,
  input  logic            head_br,
  output logic            tail_pend,
  output logic [LENW-1:0] tail_len,
  output logic            tail_br
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_pend <= 1'b0;
      tail_len  <= '0;
      tail_br   <= 1'b0;
    end else if (head_fire) begin
      tail_pend <= 1'b1;
      tail_len  <= head_len - LENW'(HEADLEN);
      tail_br   <= head_br;
    end else if (any_fire) begin
      tail_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/tsteer_row.sv
// One ring of tag units: token state, offer to the crossbar, hand-off downward
module tsteer_row import tsteer_pkg::*; #(
  parameter int NCOL     = 16,
  parameter int LENW     = 4,
  parameter int MAXSHORT = 7,
  parameter int HEADLEN  = 4,
  parameter bit START    = 1'b0,
  localparam int CW      = $clog2(NCOL)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       row_ready,
  input  logic [NCOL-1:0]            col_ready,
  input  logic [NCOL-1:0][LENW-1:0]  col_len,
  input  logic [NCOL-1:0]            col_branch,
  input  logic [NCOL-1:0]            col_target,
  input  logic                       tail_pend,
  input  logic [LENW-1:0]            tail_len,
  input  logic                       tail_br,
  input  logic                       arr_valid,
  input  logic [CW-1:0]              arr_col,
  input  logic                       arr_inject,
  output logic                       fwd_valid,
  output logic [CW-1:0]              fwd_col,
  output logic                       fwd_inject,
  output logic                       out_valid,
  output logic [CW-1:0]              out_col,
  output logic [LENW-1:0]            out_len,
  output xfer_kind_e                 out_kind,
  output logic                       fire,
  output logic [LENW-1:0]            head_len,
  output logic                       head_br,
  output logic [NCOL-1:0]            rel_mask,
  output logic [NCOL-1:0]            tag_vec,
  output logic                       inj_vec
);

  logic [NCOL-1:0] tag_q, tag_d;
  logic            inj_q, inj_d;
  logic [CW-1:0]   sel, tgt_col;
  logic            has_tag, tgt_hit, is_long, br_now;
  logic [LENW-1:0] eff_len, step;

  // Position of the tag inside this row
  always_comb begin
    sel = '0;
    for (int c = 0; c < NCOL; c++) begin
      if (tag_q[c]) sel = CW'(c);
    end
    has_tag = |tag_q;
  end

  // Lowest-numbered target column claims a pending inject token
  always_comb begin
    tgt_col = '0;
    for (int c = NCOL - 1; c >= 0; c--) begin
      if (col_target[c]) tgt_col = CW'(c);
    end
    tgt_hit = inj_q && (|col_target);
  end

  always_comb begin
    eff_len    = tail_pend ? tail_len : col_len[sel];
    is_long    = !tail_pend && (eff_len > LENW'(MAXSHORT));
    step       = is_long ? LENW'(HEADLEN) : eff_len;
    br_now     = tail_pend ? tail_br : (col_branch[sel] && !is_long);
    out_valid  = has_tag && col_ready[sel];
    fire       = out_valid && row_ready;
    fwd_valid  = fire && !br_now;
    fwd_inject = fire && br_now;
    fwd_col    = CW'(ts_wrap(int'(sel), int'(step), NCOL));
    out_col    = sel;
    out_len    = step;
    out_kind   = tail_pend ? XF_TAIL : (is_long ? XF_HEAD : XF_SHORT);
    head_len   = col_len[sel];
    head_br    = col_branch[sel];
  end

  // Columns covered by the instruction leaving this cycle
  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      rel_mask[c] = fire && (ts_wrap(c, NCOL - int'(sel), NCOL) < int'(step));
    end
  end

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      tag_d[c] = (tag_q[c] && !fire)
               || (arr_valid && (arr_col == CW'(c)))
               || (tgt_hit && (tgt_col == CW'(c)));
    end
    inj_d = (inj_q && !tgt_hit) || arr_inject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= START ? NCOL'(1) : '0;
      inj_q <= 1'b0;
    end else begin
      tag_q <= tag_d;
      inj_q <= inj_d;
    end
  end

  assign tag_vec = tag_q;
  assign inj_vec = inj_q;

endmodule

// File: rtl/torus_steer.sv
// Grid of tag-unit rows wrapped into a torus, with shared long-instruction state
module torus_steer import tsteer_pkg::*; #(
  parameter int NCOL     = 16,
  parameter int NROW     = 4,
  parameter int LENW     = 4,
  parameter int MAXSHORT = 7,
  parameter int HEADLEN  = 4,
  localparam int CW      = $clog2(NCOL)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCOL-1:0]           col_ready,
  input  logic [NCOL-1:0][LENW-1:0] col_len,
  input  logic [NCOL-1:0]           col_branch,
  input  logic [NCOL-1:0]           col_target,
  input  logic [NROW-1:0]           row_ready,
  output logic [NROW-1:0]           row_valid,
  output logic [NROW-1:0][CW-1:0]   row_col,
  output logic [NROW-1:0][LENW-1:0] row_len,
  output logic [NROW-1:0]           row_head,
  output logic [NROW-1:0]           row_tail,
  output logic [NCOL-1:0]           col_release
);

  logic [NROW-1:0]           fwd_valid_w, fwd_inj_w, fire_w, head_br_w, out_valid_w;
  logic [NROW-1:0][CW-1:0]   fwd_col_w, out_col_w;
  logic [NROW-1:0][LENW-1:0] head_len_w, out_len_w;
  xfer_kind_e                kind_w [NROW];
  logic [NROW-1:0][NCOL-1:0] rel_w, tag_all;
  logic [NROW-1:0]           inj_all;
  logic                      tail_pend, tail_br;
  logic [LENW-1:0]           tail_len;
  logic                      any_fire, head_fire, sel_head_br;
  logic [LENW-1:0]           sel_head_len;

  for (genvar r = 0; r < NROW; r++) begin : g_row
    localparam int PREV = (r + NROW - 1) % NROW;

    tsteer_row #(
      .NCOL(NCOL), .LENW(LENW), .MAXSHORT(MAXSHORT), .HEADLEN(HEADLEN),
      .START(r == 0)
    ) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_ready  (row_ready[r]),
      .col_ready  (col_ready),
      .col_len    (col_len),
      .col_branch (col_branch),
      .col_target (col_target),
      .tail_pend  (tail_pend),
      .tail_len   (tail_len),
      .tail_br    (tail_br),
      .arr_valid  (fwd_valid_w[PREV]),
      .arr_col    (fwd_col_w[PREV]),
      .arr_inject (fwd_inj_w[PREV]),
      .fwd_valid  (fwd_valid_w[r]),
      .fwd_col    (fwd_col_w[r]),
      .fwd_inject (fwd_inj_w[r]),
      .out_valid  (out_valid_w[r]),
      .out_col    (out_col_w[r]),
      .out_len    (out_len_w[r]),
      .out_kind   (kind_w[r]),
      .fire       (fire_w[r]),
      .head_len   (head_len_w[r]),
      .head_br    (head_br_w[r]),
      .rel_mask   (rel_w[r]),
      .tag_vec    (tag_all[r]),
      .inj_vec    (inj_all[r])
    );

    assign row_valid[r] = out_valid_w[r];
    assign row_col[r]   = out_col_w[r];
    assign row_len[r]   = out_len_w[r];
    assign row_head[r]  = out_valid_w[r] && (kind_w[r] == XF_HEAD);
    assign row_tail[r]  = out_valid_w[r] && (kind_w[r] == XF_TAIL);
  end

  always_comb begin
    any_fire     = |fire_w;
    head_fire    = 1'b0;
    sel_head_len = '0;
    sel_head_br  = 1'b0;
    col_release  = '0;
    for (int r = 0; r < NROW; r++) begin
      col_release = col_release | rel_w[r];
      if (fire_w[r]) begin
        head_fire    = head_fire | (kind_w[r] == XF_HEAD);
        sel_head_len = sel_head_len | head_len_w[r];
        sel_head_br  = sel_head_br | head_br_w[r];
      end
    end
  end

  tsteer_tail #(.LENW(LENW), .HEADLEN(HEADLEN)) u_tail (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_fire  (any_fire),
    .head_fire (head_fire),
    .head_len  (sel_head_len),
    .head_br   (sel_head_br),
    .tail_pend (tail_pend),
    .tail_len  (tail_len),
    .tail_br   (tail_br)
  );

endmodule

// File: rtl/tsteer_chk.sv
module tsteer_chk #(
  parameter int NCOL     = 16,
  parameter int NROW     = 4,
  parameter int LENW     = 4,
  parameter int MAXSHORT = 7,
  localparam int CW      = $clog2(NCOL)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NROW-1:0]           row_valid,
  input logic [NROW-1:0]           row_ready,
  input logic [NROW-1:0][CW-1:0]   row_col,
  input logic [NROW-1:0][LENW-1:0] row_len,
  input logic [NCOL-1:0]           col_release,
  input logic [NCOL-1:0]           col_target,
  input logic [NROW-1:0][NCOL-1:0] tag_all,
  input logic [NROW-1:0]           inj_all
);

  p_single_token_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tag_all, inj_all}) == 1);

  p_one_row_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_valid));

  p_quiet_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_valid & row_ready) == '0) |-> (col_release == '0));

  for (genvar r = 0; r < NROW; r++) begin : g_chk
    localparam int NXT = (r + 1) % NROW;

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid[r] && !row_ready[r]) |=> $stable(tag_all[r]));

    p_token_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid[r] && row_ready[r]) |=> ((tag_all[NXT] != '0) || inj_all[NXT]));

    p_release_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid[r] && row_ready[r]) |-> col_release[row_col[r]]);

    p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid[r] |-> ((row_len[r] != '0) && (row_len[r] <= LENW'(MAXSHORT))));

    p_inject_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_all[r] && (col_target != '0)) |=> (!inj_all[r] && (tag_all[r] != '0)));
  end

endmodule

bind torus_steer tsteer_chk #(
  .NCOL(NCOL), .NROW(NROW), .LENW(LENW), .MAXSHORT(MAXSHORT)
) u_tsteer_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .row_valid   (row_valid),
  .row_ready   (row_ready),
  .row_col     (row_col),
  .row_len     (row_len),
  .col_release (col_release),
  .col_target  (col_target),
  .tag_all     (tag_all),
  .inj_all     (inj_all)
);

// File: tb/torus_steer_bench.sv
module torus_steer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;
  localparam int NR = 4;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]      col_ready = '0;
  logic [NC-1:0][3:0] col_len = '0;
  logic [NC-1:0]      col_branch = '0;
  logic [NC-1:0]      col_target = '0;
  logic [NR-1:0]      row_ready = '0;
  logic [NR-1:0]      row_valid;
  logic [NR-1:0][3:0] row_col;
  logic [NR-1:0][3:0] row_len;
  logic [NR-1:0]      row_head;
  logic [NR-1:0]      row_tail;
  logic [NC-1:0]      col_release;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int m_row, m_col, m_tlen;
  bit m_inj, m_tailp, m_tbr;
  // expected values of the current cycle
  logic [NR-1:0] e_valid;
  logic [NC-1:0] e_rel;
  int  e_eff, e_step;
  bit  e_long, e_br, e_fire;

  always #(CLK_PERIOD / 2) clk = ~clk;

  torus_steer u_torus_steer (
    .clk(clk), .rst_n(rst_n), .col_ready(col_ready), .col_len(col_len),
    .col_branch(col_branch), .col_target(col_target), .row_ready(row_ready),
    .row_valid(row_valid), .row_col(row_col), .row_len(row_len),
    .row_head(row_head), .row_tail(row_tail), .col_release(col_release)
  );

  task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_row = 0; m_col = 0; m_inj = 0; m_tailp = 0; m_tlen = 0; m_tbr = 0;
  endtask

  task automatic model_eval();
    e_valid = '0;
    e_rel   = '0;
    e_eff   = m_tailp ? m_tlen : int'(col_len[m_col]);
    e_long  = !m_tailp && (e_eff > 7);
    e_step  = e_long ? 4 : e_eff;
    e_br    = m_tailp ? m_tbr : (col_branch[m_col] && !e_long);
    if (!m_inj && col_ready[m_col]) e_valid[m_row] = 1'b1;
    e_fire  = (e_valid != '0) && row_ready[m_row];
    if (e_fire) begin
      for (int i = 0; i < e_step; i++) e_rel[(m_col + i) % NC] = 1'b1;
    end
  endtask

  task automatic model_update();
    if (m_inj) begin
      int t = -1;
      for (int c = 0; c < NC; c++) if (col_target[c] && t < 0) t = c;
      if (t >= 0) begin
        m_col = t;
        m_inj = 0;
      end
    end else if (e_fire) begin
      if (e_long) begin
        m_tailp = 1; m_tlen = e_eff - 4; m_tbr = col_branch[m_col];
      end else begin
        m_tailp = 0;
      end
      if (e_br) m_inj = 1;
      else m_col = (m_col + e_step) % NC;
      m_row = (m_row + 1) % NR;
    end
  endtask

  // compare every output against the model, inputs already applied
  task automatic settle();
    #1;
    model_eval();
    check(row_valid == e_valid, "R2 row_valid", row_valid, e_valid);
    if (e_valid != '0) begin
      check(row_col[m_row] == 4'(m_col), "R5 row_col", row_col[m_row], m_col);
      check(row_len[m_row] == 4'(e_step), "R5 row_len", row_len[m_row], e_step);
      check({row_head[m_row], row_tail[m_row]} == {e_long, m_tailp},
            "R8 head/tail kind", {row_head[m_row], row_tail[m_row]}, {e_long, m_tailp});
    end
    check(col_release == e_rel, "R5 col_release", col_release, e_rel);
  endtask

  task automatic adv();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    col_ready = '0; col_len = '0; col_branch = '0; col_target = '0; row_ready = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic all_len(int l);
    for (int c = 0; c < NC; c++) col_len[c] = 4'(l);
  endtask

  task automatic rand_phase(int n, int p_br, int p_long);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < NC; c++) begin
        col_ready[c]  = ($urandom_range(0, 99) < 75);
        col_len[c]    = ($urandom_range(0, 99) < p_long) ? 4'($urandom_range(8, 11))
                                                         : 4'($urandom_range(1, 7));
        col_branch[c] = ($urandom_range(0, 99) < p_br);
        col_target[c] = ($urandom_range(0, 99) < 8);
      end
      for (int r = 0; r < NR; r++) row_ready[r] = ($urandom_range(0, 99) < 75);
      settle();
      adv();
    end
  endtask

  initial begin : main
    int path [7] = '{0, 3, 6, 9, 12, 15, 2};

    // R1: reset position
    do_reset();
    row_ready = '1; all_len(3);
    settle();
    check(row_valid == 4'b0000, "R1 idle before column 0 ready", row_valid, 0);
    adv();
    col_ready = '1;
    settle();
    check(row_valid == 4'b0001 && row_col[0] == 4'd0, "R1 first transfer row0 col0",
          {row_valid, row_col[0]}, {4'b0001, 4'd0});

    // R4: 3-byte stream walks the torus
    for (int k = 0; k < 7; k++) begin
      if (k > 0) settle();
      check(row_valid == 4'(1 << (k % 4)) && row_col[k % 4] == 4'(path[k]),
            "R4 tag path", {row_valid, row_col[k % 4]}, {4'(1 << (k % 4)), 4'(path[k])});
      adv();
    end

    // R3: stall holds, then release of 2 columns
    do_reset();
    all_len(2); col_ready = '1; row_ready = '0;
    for (int k = 0; k < 3; k++) begin
      settle();
      check(row_valid == 4'b0001 && col_release == '0, "R3 stall holds",
            {row_valid, col_release}, {4'b0001, 16'h0});
      adv();
    end
    row_ready = '1;
    settle();
    check(col_release == 16'h0003, "R5 release mask", col_release, 16'h0003);
    adv();
    settle();
    check(row_valid == 4'b0010 && row_col[1] == 4'd2, "R4 next start",
          {row_valid, row_col[1]}, {4'b0010, 4'd2});
    adv();

    // R6 / R7: branch, inject token, target pick
    do_reset();
    all_len(3); col_ready = '1; row_ready = '1;
    col_branch[3] = 1'b1; col_target[5] = 1'b1;
    settle(); adv();
    settle();
    check(row_valid == 4'b0010 && row_col[1] == 4'd3, "R7 target ignored without token",
          {row_valid, row_col[1]}, {4'b0010, 4'd3});
    check(col_release == 16'h0038, "R6 branch releases its bytes", col_release, 16'h0038);
    adv();
    col_branch = '0; col_target = '0;
    settle();
    check(row_valid == 4'b0000, "R6 no offer while token waits", row_valid, 0);
    adv();
    col_target[9] = 1'b1; col_target[12] = 1'b1;
    settle();
    check(row_valid == 4'b0000, "R6 token claimed at edge only", row_valid, 0);
    adv();
    col_target = '0;
    settle();
    check(row_valid == 4'b0100 && row_col[2] == 4'd9, "R7 lowest target claims token",
          {row_valid, row_col[2]}, {4'b0100, 4'd9});
    adv();

    // R8: long instruction head and tail
    do_reset();
    all_len(1); col_ready = '1; row_ready = '1;
    col_len[0] = 4'd10; col_len[4] = 4'd2; col_branch[4] = 1'b1;
    settle();
    check(row_len[0] == 4'd4 && row_head[0] && col_release == 16'h000F, "R8 head",
          {row_len[0], row_head[0], col_release}, {4'd4, 1'b1, 16'h000F});
    adv();
    settle();
    check(row_valid == 4'b0010 && row_col[1] == 4'd4 && row_len[1] == 4'd6 && row_tail[1],
          "R8 tail length", {row_valid, row_len[1], row_tail[1]}, {4'b0010, 4'd6, 1'b1});
    check(col_release == 16'h03F0, "R8 tail release", col_release, 16'h03F0);
    adv();
    settle();
    check(row_valid == 4'b0100 && row_col[2] == 4'd10, "R8 tail ignores own branch flag",
          {row_valid, row_col[2]}, {4'b0100, 4'd10});
    adv();

    do_reset();
    all_len(1); col_ready = '1; row_ready = '1;
    col_len[0] = 4'd9; col_branch[0] = 1'b1;
    settle(); adv();
    settle();
    check(row_len[1] == 4'd5 && col_release == 16'h01F0, "R8 tail of branching long",
          {row_len[1], col_release}, {4'd5, 16'h01F0});
    adv();
    settle();
    check(row_valid == 4'b0000, "R8 deferred branch injects", row_valid, 0);
    adv();

    // R9 and broad coverage: random traffic compared every cycle
    do_reset();
    rand_phase(3000, 0, 0);
    rand_phase(3000, 6, 6);
    check(row_valid == 4'b0000 || $countones(row_valid) == 1, "R9 single offer",
          row_valid, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d cycles expected fewer", WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule